// File: doc/BRIEF.md
# Reservation Station Pool with Result Snooping

This block holds a small set of waiting operations for one class of execution unit. A front end issues an operation into the pool. Each source operand arrives either as a value or as the tag of the station that will produce it. The pool watches a tagged result broadcast and fills any missing operand as soon as its producer announces the value. When an entry has both operands, it can be handed to the execution unit. The execution unit takes at most one entry per cycle, and among the ready entries it always gets the one issued earliest.

Each entry has a fixed nonzero name. The upper bits of that name are the pool number and the lower bits are the entry index. A result writer frees an entry by presenting its name on the completion port, and the name can then be handed out again. Tag value 0 means "no producer". Issue stalls while every entry is occupied. Age is kept as a sequence number that is stamped on each entry at issue. The number is compared modulo its width, so the oldest live entry must be less than half the counter range older than the youngest.

Top module: `rs_pool`

## Requirements
- R1: An accepted issue writes the lowest-index free entry. `iss_tag` always shows the name of that entry, `{POOL_ID, index}`, which is 4 + index with the defaults. The opcode and the immediate field are returned unchanged at dispatch.
- R2: `iss_stall` is high exactly when every entry is busy. An issue presented while stalled changes no entry.
- R3: At issue, a source whose tag is 0 takes the presented value. A source with a nonzero tag waits for that tag.
- R4: A broadcast with a nonzero tag writes its value into every waiting source of a busy entry that holds that tag, and clears that source's tag.
- R5: `dp_valid` is high when some busy entry that has not been dispatched has both source tags at 0. An entry issued or woken at one edge can dispatch from the next cycle on.
- R6: When several entries are ready, the dispatch port shows the one issued earliest, whatever its index.
- R7: An entry is dispatched once. The cycle with `dp_valid && dp_ready` marks it, and it is never offered again until it is reissued.
- R8: `done_valid` with a `done_tag` equal to a busy entry's name frees that entry. Other tag values have no effect. A freed name is offered again for issue.
- R9: After reset no entry is busy, `iss_stall` and `dp_valid` are low, and `iss_tag` names entry 0.
- R10: A broadcast in the same cycle as an issue that waits on its tag is captured by the new entry, and the new entry is not left waiting.
- R11: A broadcast carrying tag 0 changes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Opcode to store |
| iss_vj | input | W | First source value |
| iss_qj | input | TAGW | First source producer tag, 0 if value present |
| iss_vk | input | W | Second source value |
| iss_qk | input | TAGW | Second source producer tag, 0 if value present |
| iss_imm | input | AW | Address or immediate field |
| iss_stall | output | 1 | All entries busy |
| iss_tag | output | TAGW | Name of the entry the next issue fills |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAGW | Producer tag of the broadcast |
| bc_value | input | W | Broadcast result value |
| dp_ready | input | 1 | Execution unit accepts an entry |
| dp_valid | output | 1 | A ready entry is offered |
| dp_tag | output | TAGW | Name of the offered entry |
| dp_op | output | OPW | Opcode of the offered entry |
| dp_vj | output | W | First operand of the offered entry |
| dp_vk | output | W | Second operand of the offered entry |
| dp_imm | output | AW | Immediate of the offered entry |
| done_valid | input | 1 | Result written back |
| done_tag | input | TAGW | Name of the entry to free |

## Verification
The hardest condition to reach from the ports is an oldest-first choice that differs from index order. It needs an older entry in a high slot and a younger entry in a lower slot, both ready in the same cycle. A directed sequence sets this up. It frees slot 0 while older entries wait on a tag, reissues into slot 0, and then wakes the older entries with one broadcast. A random phase then mixes issues, broadcasts with tags that may or may not match, back-pressure and completions in an order that differs from issue order. A reference model in the bench predicts every port value from these inputs.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N = 3,
  parameter int W = 16,
  parameter int OPW = 4,
  parameter int AW = 12,
  parameter int PIDW = 2,
  parameter int POOL_ID = 1,
  parameter int SEQW = 16,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int TAGW = PIDW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [OPW-1:0]  iss_op,
  input  logic [W-1:0]    iss_vj,
  input  logic [TAGW-1:0] iss_qj,
  input  logic [W-1:0]    iss_vk,
  input  logic [TAGW-1:0] iss_qk,
  input  logic [AW-1:0]   iss_imm,
  output logic            iss_stall,
  output logic [TAGW-1:0] iss_tag,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [W-1:0]    bc_value,
  input  logic            dp_ready,
  output logic            dp_valid,
  output logic [TAGW-1:0] dp_tag,
  output logic [OPW-1:0]  dp_op,
  output logic [W-1:0]    dp_vj,
  output logic [W-1:0]    dp_vk,
  output logic [AW-1:0]   dp_imm,
  input  logic            done_valid,
  input  logic [TAGW-1:0] done_tag
);

  logic [N-1:0]    busy, disp, rdy;
  logic [OPW-1:0]  op  [N];
  logic [W-1:0]    vj  [N];
  logic [W-1:0]    vk  [N];
  logic [TAGW-1:0] qj  [N];
  logic [TAGW-1:0] qk  [N];
  logic [AW-1:0]   imm [N];
  logic [SEQW-1:0] seq [N];
  logic [SEQW-1:0] cnt;

  logic [IDXW-1:0] free_idx, sel;
  logic [SEQW-1:0] best_seq, age_diff;
  logic            any_rdy;

  wire [PIDW-1:0] pid = PIDW'(POOL_ID);
  wire do_issue = iss_valid && !iss_stall;
  wire fwd_j = bc_valid && (iss_qj != '0) && (iss_qj == bc_tag);
  wire fwd_k = bc_valid && (iss_qk != '0) && (iss_qk == bc_tag);
  wire take = dp_valid && dp_ready;

  assign iss_stall = &busy;
  assign iss_tag   = {pid, free_idx};

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!busy[i]) free_idx = IDXW'(i);
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      rdy[i] = busy[i] && !disp[i] && (qj[i] == '0) && (qk[i] == '0);
  end

  always_comb begin
    sel = '0;
    any_rdy = 1'b0;
    best_seq = '0;
    age_diff = '0;
    for (int i = 0; i < N; i++) begin
      age_diff = seq[i] - best_seq;
      if (rdy[i] && (!any_rdy || age_diff[SEQW-1])) begin
        sel = IDXW'(i);
        best_seq = seq[i];
        any_rdy = 1'b1;
      end
    end
  end

  assign dp_valid = any_rdy;
  assign dp_tag   = {pid, sel};
  assign dp_op    = op[sel];
  assign dp_vj    = vj[sel];
  assign dp_vk    = vk[sel];
  assign dp_imm   = imm[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      disp <= '0;
      cnt  <= '0;
    end else begin
      if (do_issue) cnt <= cnt + 1'b1;
      for (int i = 0; i < N; i++) begin
        if (do_issue && free_idx == IDXW'(i)) begin
          busy[i] <= 1'b1;
          disp[i] <= 1'b0;
          op[i]   <= iss_op;
          imm[i]  <= iss_imm;
          seq[i]  <= cnt;
          vj[i]   <= fwd_j ? bc_value : iss_vj;
          qj[i]   <= fwd_j ? '0 : iss_qj;
          vk[i]   <= fwd_k ? bc_value : iss_vk;
          qk[i]   <= fwd_k ? '0 : iss_qk;
        end else if (busy[i]) begin
          if (done_valid && done_tag == {pid, IDXW'(i)}) begin
            busy[i] <= 1'b0;
            disp[i] <= 1'b0;
          end else begin
            if (take && sel == IDXW'(i)) disp[i] <= 1'b1;
            if (bc_valid && qj[i] != '0 && qj[i] == bc_tag) begin
              vj[i] <= bc_value;
              qj[i] <= '0;
            end
            if (bc_valid && qk[i] != '0 && qk[i] == bc_tag) begin
              vk[i] <= bc_value;
              qk[i] <= '0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N = 3,
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_stall,
  input logic [TAGW-1:0] iss_qj,
  input logic [TAGW-1:0] iss_qk,
  input logic [N-1:0]    busy,
  input logic            dp_valid,
  input logic            dp_ready,
  input logic [TAGW-1:0] dp_tag,
  input logic            done_valid,
  input logic [TAGW-1:0] done_tag
);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_stall && !done_valid |=> busy == $past(busy));

  // R9
  rst_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !dp_valid && !iss_stall);

  // R5
  ready_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_stall && iss_qj == '0 && iss_qk == '0 |=> dp_valid);

  // R7
  no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && dp_ready |=> !(dp_valid && dp_tag == $past(dp_tag)));

  // R8
  freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && done_valid && done_tag == dp_tag |=> !(dp_valid && dp_tag == $past(dp_tag)));

endmodule

bind rs_pool rs_pool_chk #(.N(N), .TAGW(TAGW)) u_chk (.*);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, bc_valid = 0, dp_ready = 0, done_valid = 0;
  logic [3:0] iss_op = 0, iss_qj = 0, iss_qk = 0, bc_tag = 0, done_tag = 0;
  logic [15:0] iss_vj = 0, iss_vk = 0, bc_value = 0;
  logic [11:0] iss_imm = 0;
  logic iss_stall, dp_valid;
  logic [3:0] iss_tag, dp_tag, dp_op;
  logic [15:0] dp_vj, dp_vk;
  logic [11:0] dp_imm;

  rs_pool dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  bit m_busy[N], m_disp[N];
  logic [3:0] m_op[N], m_qj[N], m_qk[N];
  logic [15:0] m_vj[N], m_vk[N];
  logic [11:0] m_imm[N];
  int m_age[N];
  int age_cnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int free_slot();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int pick();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_disp[i] && m_qj[i] == 0 && m_qk[i] == 0)
        if (b < 0 || m_age[i] < m_age[b]) b = i;
    return b;
  endfunction

  task automatic compare();
    int f = free_slot();
    int p = pick();
    chk("R2 stall", iss_stall, f < 0);
    if (f >= 0) chk("R1 iss_tag", iss_tag, 4 + f);
    chk("R5 dp_valid", dp_valid, p >= 0);
    if (p >= 0) begin
      chk("R6 dp_tag", dp_tag, 4 + p);
      chk("R1 dp_op", dp_op, m_op[p]);
      chk("R1 dp_imm", dp_imm, m_imm[p]);
      chk("R3/R4 dp_vj", dp_vj, m_vj[p]);
      chk("R3/R4 dp_vk", dp_vk, m_vk[p]);
    end
  endtask

  task automatic cyc();
    int f, p;
    #1 compare();
    f = free_slot();
    p = pick();
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (iss_valid && f == i) begin
        m_busy[i] = 1; m_disp[i] = 0; m_op[i] = iss_op; m_imm[i] = iss_imm;
        m_age[i] = age_cnt;
        if (bc_valid && iss_qj != 0 && iss_qj == bc_tag) begin m_vj[i] = bc_value; m_qj[i] = 0; end
        else begin m_vj[i] = iss_vj; m_qj[i] = iss_qj; end
        if (bc_valid && iss_qk != 0 && iss_qk == bc_tag) begin m_vk[i] = bc_value; m_qk[i] = 0; end
        else begin m_vk[i] = iss_vk; m_qk[i] = iss_qk; end
      end else if (m_busy[i]) begin
        if (done_valid && done_tag == 4 + i) begin m_busy[i] = 0; m_disp[i] = 0; end
        else begin
          if (dp_ready && p == i) m_disp[i] = 1;
          if (bc_valid && m_qj[i] != 0 && m_qj[i] == bc_tag) begin m_vj[i] = bc_value; m_qj[i] = 0; end
          if (bc_valid && m_qk[i] != 0 && m_qk[i] == bc_tag) begin m_vk[i] = bc_value; m_qk[i] = 0; end
        end
      end
    end
    if (iss_valid && f >= 0) age_cnt++;
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 0; bc_valid = 0; dp_ready = 0; done_valid = 0;
  endtask

  task automatic issue(logic [3:0] op, logic [15:0] vj, logic [3:0] qj,
                       logic [15:0] vk, logic [3:0] qk, logic [11:0] imm);
    iss_valid = 1; iss_op = op; iss_vj = vj; iss_qj = qj;
    iss_vk = vk; iss_qk = qk; iss_imm = imm;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_disp[i] = 0; end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    chk("R9 stall", iss_stall, 0);
    chk("R9 dp_valid", dp_valid, 0);
    chk("R9 iss_tag", iss_tag, 4);

    // R3 fill pool: first waits on tag 7, others ready
    idle(); issue(4'h1, 16'h1111, 4'd7, 16'h2222, 4'd0, 12'h101); cyc();
    idle(); issue(4'h2, 16'h3333, 4'd0, 16'h4444, 4'd0, 12'h102); cyc();
    idle(); issue(4'h3, 16'h5555, 4'd0, 16'h6666, 4'd0, 12'h103); cyc();
    // R2 stalled issue ignored
    idle(); issue(4'hF, 16'hDEAD, 4'd0, 16'hBEEF, 4'd0, 12'hFFF); cyc();
    // R6/R7 dispatch older ready entries in order
    idle(); dp_ready = 1; cyc();
    idle(); dp_ready = 1; cyc();
    // R11 tag 0 broadcast is ignored
    idle(); bc_valid = 1; bc_tag = 0; bc_value = 16'hAAAA; cyc();
    // R4 wake entry 0 via tag 7
    idle(); bc_valid = 1; bc_tag = 7; bc_value = 16'h7777; cyc();
    idle(); dp_ready = 1; cyc();
    // R8 other pool tag ignored, then free entry 1
    idle(); done_valid = 1; done_tag = 4'd2; cyc();
    idle(); done_valid = 1; done_tag = 4'd5; cyc();
    #1 chk("R8 reuse tag", iss_tag, 5);
    // R10 same-cycle forward
    idle(); issue(4'h4, 16'h0, 4'd3, 16'h9, 4'd0, 12'h104);
    bc_valid = 1; bc_tag = 3; bc_value = 16'h3C3C; cyc();
    idle(); cyc();
    #1 chk("R10 forward ready", dp_valid, 1);
    idle(); dp_ready = 1; cyc();
    // R6 oldest in a high slot vs younger in slot 0
    idle(); done_valid = 1; done_tag = 4'd4; cyc();
    idle(); done_valid = 1; done_tag = 4'd5; cyc();
    idle(); done_valid = 1; done_tag = 4'd6; cyc();
    idle(); issue(4'h5, 16'h0, 4'd9, 16'h1, 4'd0, 12'h105); cyc();
    idle(); issue(4'h6, 16'h0, 4'd9, 16'h2, 4'd0, 12'h106); cyc();
    idle(); done_valid = 1; done_tag = 4'd4; cyc();
    idle(); issue(4'h7, 16'h0, 4'd9, 16'h3, 4'd0, 12'h107); cyc();
    idle(); bc_valid = 1; bc_tag = 9; bc_value = 16'h0909; cyc();
    #1 chk("R6 oldest wins over slot 0", dp_tag, 5);
    idle(); dp_ready = 1; cyc();
    idle(); dp_ready = 1; cyc();
    idle(); dp_ready = 1; cyc();
    for (int t = 4; t < 7; t++) begin idle(); done_valid = 1; done_tag = 4'(t); cyc(); end

    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(1, 0) == 1)
        issue(4'($urandom), 16'($urandom),
              ($urandom_range(1, 0) == 1) ? 4'd0 : 4'($urandom_range(7, 1)),
              16'($urandom),
              ($urandom_range(1, 0) == 1) ? 4'd0 : 4'($urandom_range(7, 1)),
              12'($urandom));
      if ($urandom_range(9, 0) < 4) begin
        bc_valid = 1; bc_tag = 4'($urandom_range(7, 0)); bc_value = 16'($urandom);
      end
      dp_ready = ($urandom_range(9, 0) < 7);
      if ($urandom_range(9, 0) < 3) begin
        done_valid = 1;
        done_tag = ($urandom_range(4, 0) == 0) ? 4'd2 : 4'($urandom_range(6, 4));
      end
      cyc();
    end
    idle();
    finish_run();
  end
endmodule